// File: doc/BRIEF.md
# Address-Threshold Write-Protect Controller

This block sits between the command decoder of a serial non-volatile memory and its programming sequencer, and rules on every decoded command. For each command strobe it answers, one clock later, with either a one-cycle permit pulse or a one-cycle abort pulse; permitted commands that program the array or the protect register also raise a start strobe toward the sequencer, along with the command code.

Four pieces of state drive the decision: a programming-enable latch, a protect threshold (an address plus a separate "cleared" flag), a one-shot arming flag and a permanent lock flag. Single-word writes and erases are fenced off at and above the threshold; whole-array operations need the threshold cleared. Changing the threshold takes an arming command placed directly in front of the change, and a lock command freezes the threshold for good. The threshold value and its cleared flag are driven out for readback. Persistence across power loss is modelled by the reset values `RST_THR` and `RST_CLEARED`.

Command codes on `cmd_op`: 0 read, 1 word write, 2 word erase, 3 erase-all, 4 write-all, 5 enable, 6 disable, 7 protect read, 8 arm, 9 protect clear, 10 set threshold, 11 lock; codes 12 to 15 are always aborted.

Top module: `wp_guard`

## Requirements
- R1: After reset the enable latch is clear, the threshold is cleared (`thr_clear`=1), `permit`, `abort` and `prog_start` are 0, and any write or erase is aborted until an enable command is permitted.
- R2: Enable (code 5) is permitted only with `pin_pe`=1; once permitted, programming stays allowed until a permitted disable (code 6) or a reset.
- R3: With the threshold set, a word write (1) or erase (2) is aborted when its address is greater than or equal to `thr_value` and permitted (given enable, `pin_pe`=1) when below it.
- R4: Erase-all (3) and write-all (4) are permitted only while `thr_clear`=1 (and enable is set, `pin_pe`=1).
- R5: Arm (8) is permitted only with the enable latch set and `pin_pe`=`pin_pre`=1; the arming is used up by the next command of any kind, so a command in between leaves a following protect change aborted.
- R6: Protect clear (9), set threshold (10) and lock (11) are permitted only when the previous command was a permitted arm and `pin_pe`=`pin_pre`=1 during the command.
- R7: Set threshold is permitted only while `thr_clear`=1; when permitted, `thr_value` takes `cmd_addr` and `thr_clear` becomes 0.
- R8: After a permitted lock, every clear, set threshold and further lock is aborted and `thr_value`/`thr_clear` never change again.
- R9: Codes 0 to 6 need `pin_pre`=0 and codes 7 to 11 need `pin_pre`=1; a command on the wrong pin level is aborted. Protect read (7) is otherwise always permitted.
- R10: Read (0) is permitted with `pin_pre`=0 whether the enable latch is set or clear, and never raises `prog_start`.
- R11: While `thr_clear`=1 no address is protected, including the top address 255.
- R12: Each `cmd_valid` cycle is answered in the next cycle by exactly one of `permit` or `abort`, with no pulse otherwise; `prog_start` pulses with `permit` for codes 1 to 4 and 9 to 11 and `prog_op` then holds the code; an aborted command changes neither the threshold, its cleared flag nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a decoded command is presented |
| cmd_op | input | 4 | Decoded command code |
| cmd_addr | input | 8 | Command address |
| pin_pe | input | 1 | Sampled program-enable pin level |
| pin_pre | input | 1 | Sampled protect-enable pin level |
| permit | output | 1 | One-cycle pulse: last command may run |
| abort | output | 1 | One-cycle pulse: last command refused |
| prog_start | output | 1 | One-cycle start strobe for the programming sequencer |
| prog_op | output | 4 | Code of the last presented command |
| thr_value | output | 8 | Stored protect threshold address |
| thr_clear | output | 1 | 1 when the threshold is in the cleared state |

## Verification
The hardest state to reach is a locked threshold, because it needs the full chain enable, arm, set threshold, arm, lock with the right pin levels on each step, and the arming flag evaporates if anything slips in between. The stimulus builds that chain step by step, first proving each link fails on its own (arm with the latch clear, set without arm, arm consumed by a read, set over an already set threshold), then locks and retries clear, set and lock after fresh arms to show they are all refused and the threshold stays put.

// File: rtl/wp_pkg.sv
// Package: command codes and shared width for the write-protect controller.
// Assumes the decoder upstream already maps serial opcodes to these codes.
package wp_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_READ      = 4'd0,
        OP_WRITE     = 4'd1,
        OP_ERASE     = 4'd2,
        OP_ERASE_ALL = 4'd3,
        OP_WRITE_ALL = 4'd4,
        OP_ENABLE    = 4'd5,
        OP_DISABLE   = 4'd6,
        OP_PR_READ   = 4'd7,
        OP_ARM       = 4'd8,
        OP_PR_CLEAR  = 4'd9,
        OP_PR_SET    = 4'd10,
        OP_PR_LOCK   = 4'd11
    } wp_op_e;

    // True for commands that start a programming cycle when permitted.
    function automatic logic op_programs(input wp_op_e op);
        case (op)
            OP_WRITE, OP_ERASE, OP_ERASE_ALL, OP_WRITE_ALL,
            OP_PR_CLEAR, OP_PR_SET, OP_PR_LOCK: op_programs = 1'b1;
            default:                            op_programs = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/wp_decide.sv
// Module: wp_decide
// Pure combinational verdict on one command from the current protect state
// and the sampled pin levels. Unknown codes are refused.
// Assumes all state inputs are registered values from wp_state.
module wp_decide
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  wp_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pe,
    input  logic              pre,
    input  logic              en_q,
    input  logic              armed_q,
    input  logic              clear_q,
    input  logic              lock_q,
    input  logic [ADDR_W-1:0] thr_q,
    output logic              ok,
    output logic              programs
);
    logic below_thr;
    logic pr_gate;
    logic prog_gate;

    // Address is outside the fenced region when cleared or below threshold.
    assign below_thr = clear_q || (addr < thr_q);
    // Common conditions for protect-register changes.
    assign pr_gate   = pre && pe && armed_q && !lock_q;
    // Common conditions for array programming.
    assign prog_gate = !pre && pe && en_q;

    // Per-command permission table.
    always_comb begin
        case (op)
            OP_READ:      ok = !pre;
            OP_WRITE,
            OP_ERASE:     ok = prog_gate && below_thr;
            OP_ERASE_ALL,
            OP_WRITE_ALL: ok = prog_gate && clear_q;
            OP_ENABLE:    ok = !pre && pe;
            OP_DISABLE:   ok = !pre;
            OP_PR_READ:   ok = pre;
            OP_ARM:       ok = pre && pe && en_q;
            OP_PR_CLEAR,
            OP_PR_LOCK:   ok = pr_gate;
            OP_PR_SET:    ok = pr_gate && clear_q;
            default:      ok = 1'b0;
        endcase
    end

    assign programs = op_programs(op);
endmodule

// File: rtl/wp_state.sv
// Module: wp_state
// Holds the enable latch, one-shot arming flag, threshold, cleared flag and
// lock flag; updates them only on a presented command that was permitted,
// except the arming flag, which every presented command rewrites.
// Assumes synchronous active-low reset; reset values model retained contents.
module wp_state
    import wp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] RST_THR     = '0,
    parameter logic              RST_CLEARED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  wp_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ok,
    output logic              en_q,
    output logic              armed_q,
    output logic              clear_q,
    output logic              lock_q,
    output logic [ADDR_W-1:0] thr_q
);
    logic take;
    assign take = cmd_valid && ok;

    // Programming-enable latch: set by enable, dropped by disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b0;
        else if (take && op == OP_ENABLE)    en_q <= 1'b1;
        else if (take && op == OP_DISABLE)   en_q <= 1'b0;
    end

    // One-shot arming: lives exactly until the next presented command.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (cmd_valid) armed_q <= take && (op == OP_ARM);
    end

    // Threshold and its cleared flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_q <= RST_CLEARED;
            thr_q   <= RST_THR;
        end else if (take && op == OP_PR_CLEAR) begin
            clear_q <= 1'b1;
        end else if (take && op == OP_PR_SET) begin
            clear_q <= 1'b0;
            thr_q   <= addr;
        end
    end

    // Permanent lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                        lock_q <= 1'b0;
        else if (take && op == OP_PR_LOCK) lock_q <= 1'b1;
    end
endmodule

// File: rtl/wp_resp.sv
// Module: wp_resp
// Registers the verdict into one-cycle permit/abort pulses and the
// sequencer start strobe; remembers the last command code.
module wp_resp
    import wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  wp_op_e          op,
    input  logic            ok,
    input  logic            programs,
    output logic            permit,
    output logic            abort,
    output logic            prog_start,
    output logic [OP_W-1:0] prog_op
);
    // Verdict pulses, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            permit     <= 1'b0;
            abort      <= 1'b0;
            prog_start <= 1'b0;
        end else begin
            permit     <= cmd_valid && ok;
            abort      <= cmd_valid && !ok;
            prog_start <= cmd_valid && ok && programs;
        end
    end

    // Last presented code for the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)         prog_op <= '0;
        else if (cmd_valid) prog_op <= op;
    end
endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard (top)
// Write-protect controller: rules on each decoded command and drives the
// verdict, the sequencer start strobe and the threshold readback.
// Assumes cmd_valid is a single-cycle strobe with pins sampled alongside it.
module wp_guard
    import wp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] RST_THR     = '0,
    parameter logic              RST_CLEARED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              pin_pe,
    input  logic              pin_pre,
    output logic              permit,
    output logic              abort,
    output logic              prog_start,
    output logic [OP_W-1:0]   prog_op,
    output logic [ADDR_W-1:0] thr_value,
    output logic              thr_clear
);
    wp_op_e op;
    logic   ok, programs;
    logic   en_q, armed_q, clear_q, lock_q;
    logic [ADDR_W-1:0] thr_q;

    assign op = wp_op_e'(cmd_op);

    wp_decide #(.ADDR_W(ADDR_W)) u_decide (
        .op(op), .addr(cmd_addr), .pe(pin_pe), .pre(pin_pre),
        .en_q(en_q), .armed_q(armed_q), .clear_q(clear_q),
        .lock_q(lock_q), .thr_q(thr_q), .ok(ok), .programs(programs)
    );

    wp_state #(.ADDR_W(ADDR_W), .RST_THR(RST_THR), .RST_CLEARED(RST_CLEARED)) u_state (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op),
        .addr(cmd_addr), .ok(ok), .en_q(en_q), .armed_q(armed_q),
        .clear_q(clear_q), .lock_q(lock_q), .thr_q(thr_q)
    );

    wp_resp u_resp (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .op(op),
        .ok(ok), .programs(programs), .permit(permit), .abort(abort),
        .prog_start(prog_start), .prog_op(prog_op)
    );

    assign thr_value = thr_q;
    assign thr_clear = clear_q;
endmodule

// File: rtl/wp_guard_chk.sv
// Module: wp_guard_chk
// Temporal checks on the controller, attached by bind.
module wp_guard_chk
    import wp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              permit,
    input logic              abort,
    input logic              prog_start,
    input logic [OP_W-1:0]   prog_op,
    input logic [ADDR_W-1:0] thr_value,
    input logic              thr_clear,
    input logic              en_q,
    input logic              armed_q,
    input logic              lock_q
);
    p_one_verdict_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (permit ^ abort));

    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> (!permit && !abort && !prog_start));

    p_abort_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ($stable(thr_value) && $stable(thr_clear) && $stable(lock_q)));

    p_word_fence_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && (prog_op == OP_WRITE || prog_op == OP_ERASE))
        |-> (thr_clear || ($past(cmd_addr) < thr_value)));

    p_array_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && (prog_op == OP_ERASE_ALL || prog_op == OP_WRITE_ALL))
        |-> thr_clear);

    p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && prog_op >= 4'd1 && prog_op <= 4'd4) |-> $past(en_q));

    p_arm_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op != OP_ARM) |=> !armed_q);

    p_locked_refuses_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && cmd_valid && (cmd_op == OP_PR_CLEAR || cmd_op == OP_PR_SET
                                 || cmd_op == OP_PR_LOCK)) |=> abort);

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (lock_q && $stable(thr_value) && $stable(thr_clear)));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .permit(permit), .abort(abort),
    .prog_start(prog_start), .prog_op(prog_op), .thr_value(thr_value),
    .thr_clear(thr_clear), .en_q(en_q), .armed_q(armed_q), .lock_q(lock_q)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] C_READ = 4'd0, C_WR = 4'd1, C_ER = 4'd2,
        C_ERALL = 4'd3, C_WRALL = 4'd4, C_EN = 4'd5, C_DIS = 4'd6,
        C_PRRD = 4'd7, C_ARM = 4'd8, C_CLR = 4'd9, C_SET = 4'd10, C_LOCK = 4'd11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_addr = '0;
    logic       pin_pe = 1'b0;
    logic       pin_pre = 1'b0;
    logic       permit, abort, prog_start, thr_clear;
    logic [3:0] prog_op;
    logic [7:0] thr_value;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic r_perm, r_abort, r_start;
    logic [3:0] r_op;

    wp_guard dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .pin_pe(pin_pe), .pin_pre(pin_pre),
        .permit(permit), .abort(abort), .prog_start(prog_start),
        .prog_op(prog_op), .thr_value(thr_value), .thr_clear(thr_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one command; capture the verdict one cycle later.
    task automatic issue(input logic [3:0] op, input logic [7:0] a,
                         input logic pe, input logic pre);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; pin_pe = pe; pin_pre = pre; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        r_perm = permit; r_abort = abort; r_start = prog_start; r_op = prog_op;
    endtask

    // Check verdict pair, start strobe and code.
    task automatic expect_cmd(input string tag, input logic exp_ok, input logic exp_start);
        chk({tag, " permit"}, int'(r_perm), int'(exp_ok));
        chk({tag, " abort"}, int'(r_abort), int'(!exp_ok));
        chk({tag, " prog_start"}, int'(r_start), int'(exp_start));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset thr_clear", int'(thr_clear), 1);
        chk("R1 reset permit", int'(permit), 0);
        chk("R1 reset abort", int'(abort), 0);
        chk("R1 reset prog_start", int'(prog_start), 0);
        issue(C_WR, 8'd5, 1'b1, 1'b0);
        expect_cmd("R1 write before enable", 1'b0, 1'b0);
        issue(C_ERALL, 8'd0, 1'b1, 1'b0);
        expect_cmd("R1 erase-all before enable", 1'b0, 1'b0);
    endtask

    task automatic t_enable();
        issue(C_EN, 8'd0, 1'b0, 1'b0);
        expect_cmd("R2 enable with pe low", 1'b0, 1'b0);
        issue(C_WR, 8'd5, 1'b1, 1'b0);
        expect_cmd("R2 write after refused enable", 1'b0, 1'b0);
        issue(C_EN, 8'd0, 1'b1, 1'b0);
        expect_cmd("R2 enable", 1'b1, 1'b0);
        issue(C_WR, 8'd5, 1'b1, 1'b0);
        expect_cmd("R12 write permitted", 1'b1, 1'b1);
        chk("R12 prog_op", int'(r_op), int'(C_WR));
        @(negedge clk);
        chk("R12 idle no pulse", int'(permit | abort | prog_start), 0);
        issue(C_ER, 8'd6, 1'b1, 1'b0);
        expect_cmd("R2 enable persists", 1'b1, 1'b1);
        issue(C_DIS, 8'd0, 1'b0, 1'b0);
        expect_cmd("R2 disable", 1'b1, 1'b0);
        issue(C_WR, 8'd5, 1'b1, 1'b0);
        expect_cmd("R2 write after disable", 1'b0, 1'b0);
    endtask

    task automatic t_read();
        issue(C_READ, 8'd9, 1'b0, 1'b0);
        expect_cmd("R10 read while disabled", 1'b1, 1'b0);
        issue(C_EN, 8'd0, 1'b1, 1'b0);
        expect_cmd("R2 re-enable", 1'b1, 1'b0);
        issue(C_READ, 8'd9, 1'b1, 1'b0);
        expect_cmd("R10 read while enabled", 1'b1, 1'b0);
        issue(C_READ, 8'd9, 1'b0, 1'b1);
        expect_cmd("R9 read with pre high", 1'b0, 1'b0);
        issue(C_WR, 8'd1, 1'b1, 1'b1);
        expect_cmd("R9 write with pre high", 1'b0, 1'b0);
        issue(4'd13, 8'd0, 1'b1, 1'b0);
        expect_cmd("R9 unknown code", 1'b0, 1'b0);
    endtask

    task automatic t_cleared_top();
        issue(C_WR, 8'd255, 1'b1, 1'b0);
        expect_cmd("R11 top address while cleared", 1'b1, 1'b1);
        issue(C_WRALL, 8'd0, 1'b1, 1'b0);
        expect_cmd("R4 write-all while cleared", 1'b1, 1'b1);
    endtask

    task automatic t_arm();
        issue(C_ARM, 8'd0, 1'b1, 1'b0);
        expect_cmd("R9 arm with pre low", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b0, 1'b1);
        expect_cmd("R5 arm with pe low", 1'b0, 1'b0);
        issue(C_SET, 8'h40, 1'b1, 1'b1);
        expect_cmd("R6 set without arm", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_PRRD, 8'd0, 1'b0, 1'b1);
        expect_cmd("R9 protect read", 1'b1, 1'b0);
        issue(C_SET, 8'h40, 1'b1, 1'b1);
        expect_cmd("R5 arm used by protect read", 1'b0, 1'b0);
        chk("R12 thr_clear after abort", int'(thr_clear), 1);
        issue(C_DIS, 8'd0, 1'b0, 1'b0);
        expect_cmd("R2 disable", 1'b1, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm needs enable", 1'b0, 1'b0);
        issue(C_EN, 8'd0, 1'b1, 1'b0);
        expect_cmd("R2 enable again", 1'b1, 1'b0);
    endtask

    task automatic t_threshold();
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_SET, 8'h40, 1'b1, 1'b1);
        expect_cmd("R7 set threshold", 1'b1, 1'b1);
        chk("R7 thr_value", int'(thr_value), 8'h40);
        chk("R7 thr_clear", int'(thr_clear), 0);
        issue(C_WR, 8'h3F, 1'b1, 1'b0);
        expect_cmd("R3 write below", 1'b1, 1'b1);
        issue(C_WR, 8'h40, 1'b1, 1'b0);
        expect_cmd("R3 write at threshold", 1'b0, 1'b0);
        issue(C_ER, 8'hFF, 1'b1, 1'b0);
        expect_cmd("R3 erase above", 1'b0, 1'b0);
        issue(C_ERALL, 8'd0, 1'b1, 1'b0);
        expect_cmd("R4 erase-all while set", 1'b0, 1'b0);
        issue(C_WRALL, 8'd0, 1'b1, 1'b0);
        expect_cmd("R4 write-all while set", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_SET, 8'h10, 1'b1, 1'b1);
        expect_cmd("R7 set over set threshold", 1'b0, 1'b0);
        chk("R7 thr_value kept", int'(thr_value), 8'h40);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_CLR, 8'hFF, 1'b0, 1'b1);
        expect_cmd("R6 clear with pe low", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_CLR, 8'hFF, 1'b1, 1'b1);
        expect_cmd("R6 clear", 1'b1, 1'b1);
        chk("R6 thr_clear after clear", int'(thr_clear), 1);
        issue(C_ERALL, 8'd0, 1'b1, 1'b0);
        expect_cmd("R4 erase-all after clear", 1'b1, 1'b1);
    endtask

    task automatic t_lock();
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_SET, 8'h80, 1'b1, 1'b1);
        expect_cmd("R7 set 0x80", 1'b1, 1'b1);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm", 1'b1, 1'b0);
        issue(C_LOCK, 8'd0, 1'b1, 1'b1);
        expect_cmd("R6 lock", 1'b1, 1'b1);
        chk("R12 prog_op lock", int'(r_op), int'(C_LOCK));
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm after lock", 1'b1, 1'b0);
        issue(C_CLR, 8'hFF, 1'b1, 1'b1);
        expect_cmd("R8 clear after lock", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm after lock", 1'b1, 1'b0);
        issue(C_SET, 8'h00, 1'b1, 1'b1);
        expect_cmd("R8 set after lock", 1'b0, 1'b0);
        issue(C_ARM, 8'd0, 1'b1, 1'b1);
        expect_cmd("R5 arm after lock", 1'b1, 1'b0);
        issue(C_LOCK, 8'd0, 1'b1, 1'b1);
        expect_cmd("R8 second lock", 1'b0, 1'b0);
        chk("R8 thr_value frozen", int'(thr_value), 8'h80);
        chk("R8 thr_clear frozen", int'(thr_clear), 0);
        issue(C_WR, 8'h7F, 1'b1, 1'b0);
        expect_cmd("R3 write below locked", 1'b1, 1'b1);
        issue(C_WR, 8'hFF, 1'b1, 1'b0);
        expect_cmd("R3 top address fenced", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_read();
        t_cleared_top();
        t_arm();
        t_threshold();
        t_lock();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule